// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns parallel PCM samples into a framed serial audio stream and drives the bit clock and frame sync itself. A divider derives the bit clock from the system clock. A free-running position counter, whose length is the programmed frame period, lays each frame out bit by bit. Two framing styles share one datapath. In the two-channel-word style (I2S) a low frame sync marks the first channel's word and outputs change on the falling bit-clock edge. In the short-pulse style (DSP mode A) a one-bit high sync opens the frame and outputs change on the rising bit-clock edge.

Samples arrive over a valid/ready handshake, one word per channel, left-aligned on a 32-bit bus. A missing sample is replaced by zeros and flagged. Enable and disable requests take effect only at frame boundaries, so a frame is never cut short. Settings that the frame cannot hold are reported and keep the transmitter stopped.

Top module: `serial_audio_tx`

## Requirements
- R1: `bclk` toggles every `clkDiv` system clock cycles and runs without gaps. With `clkDiv` = 0 it holds its level, and no frame position advances.
- R2: `widthSel` = 0, 1, 2, 3 selects a sample width W of 8, 16, 24 or 32 bits. The sample sits left-aligned on `sampleData`, so bit 31 is sent first and only the top W bits go out.
- R3: With `fmtDsp` = 0, `fsync` is 0 at frame positions 0 to W-1 and 1 at positions W to F-1, where F is `framePeriod`. It idles at 1.
- R4: With `fmtDsp` = 0, `sdata` and `fsync` change only together with a falling edge of `bclk`.
- R5: With `fmtDsp` = 1, `fsync` is 1 only at frame position 0 and idles at 0. `sdata` and `fsync` change only together with a rising edge of `bclk`.
- R6: The first channel's word occupies positions 1 to W. When `stereo` = 1, the second channel's word occupies positions W+1 to 2W. Every other position carries 0.
- R7: A frame lasts exactly `framePeriod` bit-clock update edges.
- R8: `sampleReady` is a single-cycle pulse at the start of each word, one per channel per frame. A sample is taken when `sampleValid` is high in that cycle.
- R9: If `sampleValid` is low when `sampleReady` pulses, that word is sent as zeros and `underrun` pulses for one cycle in the next clock cycle.
- R10: `cfgError` is 1 when `fmtDsp` = 0 with W above 16, or when `framePeriod` < 1 + W times the channel count. While it is 1, an enable does not start transmission.
- R11: An `enSet` pulse starts transmission at the next frame boundary. An `enClr` pulse stops it only after the current frame is complete. `txEnd` is 1 exactly while stopped, and `sdata` is 0 then.
- R12: After reset, `txEnd` = 1 and `bclk`, `sdata`, `sampleReady` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enSet | input | 1 | Request to start transmission |
| enClr | input | 1 | Request to stop at the frame boundary |
| fmtDsp | input | 1 | 0 = I2S framing, 1 = DSP mode A framing |
| widthSel | input | 2 | Sample width code (8/16/24/32) |
| stereo | input | 1 | 0 = one channel, 1 = two channels |
| clkDiv | input | DIV_W | Bit-clock half period in system cycles; 0 stops the clock |
| framePeriod | input | PER_W | Frame length in bit clocks |
| sampleValid | input | 1 | Sample available |
| sampleData | input | DATA_W | Left-aligned sample |
| sampleReady | output | 1 | Word start; sample taken this cycle |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data, MSB first |
| underrun | output | 1 | Word sent as zeros for lack of a sample |
| txEnd | output | 1 | Transmitter stopped |
| cfgError | output | 1 | Unsupported settings |

## Verification
The assertions check on every cycle the properties that involve only a few signals. They check that the bit clock freezes at a zero divider and that an underrun follows only an unserved ready. They also check that ready never pulses while stopped, that the data line is quiet while stopped, that a rejected setting never starts a frame, and that a stop lands on a bit-clock edge. Other behaviours depend on a whole frame: bit order, left alignment, slot placement per channel, sync shape per framing style, frame length, the edge each style updates on, and the divider's half period. Only the bench's sweep shows these. It rebuilds every frame from the samples handed over and compares it position by position.

// File: rtl/sat_pkg.sv
package sat_pkg;

  // strobes from frame control to the shift datapath
  typedef struct packed {
    logic tick;    // bit-clock update edge
    logic load;    // first bit of a word
    logic dataOn;  // position lies inside a word
  } txStrobe_t;

  // width code to sample bits: 8, 16, 24, 32
  function automatic logic [6:0] slotBits(input logic [1:0] sel);
    return 7'({sel, 3'b000}) + 7'd8;
  endfunction

endpackage

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enSet,
  input  logic             enClr,
  input  logic             fmtDsp,
  input  logic [1:0]       widthSel,
  input  logic             stereo,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [PER_W-1:0] framePeriod,
  output logic             bclk,
  output logic             fsync,
  output logic             txEnd,
  output logic             cfgError,
  output txStrobe_t        strobe
);
  localparam int CMP_W = ((PER_W > 8) ? PER_W : 8) + 1;

  logic [DIV_W-1:0] divCnt;
  logic             bclkQ;
  logic             halfEnd, tick;

  assign halfEnd = (clkDiv != '0) && (divCnt >= clkDiv - DIV_W'(1));
  assign tick    = halfEnd && (fmtDsp ? !bclkQ : bclkQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      bclkQ  <= 1'b0;
    end else if (clkDiv == '0) begin
      divCnt <= '0;
    end else if (halfEnd) begin
      divCnt <= '0;
      bclkQ  <= ~bclkQ;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // frame geometry
  logic [6:0]       wBits;
  logic [CMP_W-1:0] wExt, dataEnd, fpExt, posInc, nextExt;
  logic [PER_W-1:0] pos, nextPos;
  logic             wrap, running, runNext, enReq;

  assign wBits    = slotBits(widthSel);
  assign wExt     = CMP_W'(wBits);
  assign dataEnd  = stereo ? (wExt << 1) : wExt;
  assign fpExt    = CMP_W'(framePeriod);
  assign cfgError = (!fmtDsp && widthSel[1]) || (fpExt < dataEnd + CMP_W'(1));

  assign posInc  = CMP_W'(pos) + CMP_W'(1);
  assign wrap    = posInc >= fpExt;
  assign nextPos = wrap ? '0 : PER_W'(posInc);
  assign nextExt = CMP_W'(nextPos);
  assign runNext = wrap ? (enReq && !cfgError) : running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReq <= 1'b0;
    end else if (enClr) begin
      enReq <= 1'b0;
    end else if (enSet) begin
      enReq <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos     <= '1;
      running <= 1'b0;
      fsync   <= 1'b1;
    end else if (tick) begin
      pos     <= nextPos;
      running <= runNext;
      if (!runNext)    fsync <= !fmtDsp;
      else if (fmtDsp) fsync <= (nextPos == '0);
      else             fsync <= (nextExt >= wExt);
    end
  end

  assign strobe.tick   = tick;
  assign strobe.load   = tick && runNext &&
                         ((nextExt == CMP_W'(1)) || (stereo && (nextExt == wExt + CMP_W'(1))));
  assign strobe.dataOn = tick && runNext && (nextExt >= CMP_W'(1)) && (nextExt <= dataEnd);

  assign bclk  = bclkQ;
  assign txEnd = !running;

endmodule

// File: rtl/sat_dpath.sv
module sat_dpath
  import sat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  output logic              sdata,
  output logic              underrun
);
  logic [DATA_W-1:0] shReg, word;

  assign word = sampleValid ? sampleData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      sdata    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= strobe.load && !sampleValid;
      if (strobe.tick) begin
        if (strobe.load) begin
          sdata <= word[DATA_W-1];
          shReg <= word << 1;
        end else if (strobe.dataOn) begin
          sdata <= shReg[DATA_W-1];
          shReg <= shReg << 1;
        end else begin
          sdata <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import sat_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int PER_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enSet,
  input  logic              enClr,
  input  logic              fmtDsp,
  input  logic [1:0]        widthSel,
  input  logic              stereo,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [PER_W-1:0]  framePeriod,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  output logic              sampleReady,
  output logic              bclk,
  output logic              fsync,
  output logic              sdata,
  output logic              underrun,
  output logic              txEnd,
  output logic              cfgError
);
  txStrobe_t strobe;

  sat_ctrl #(.DIV_W(DIV_W), .PER_W(PER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enSet(enSet), .enClr(enClr),
    .fmtDsp(fmtDsp), .widthSel(widthSel), .stereo(stereo),
    .clkDiv(clkDiv), .framePeriod(framePeriod),
    .bclk(bclk), .fsync(fsync), .txEnd(txEnd), .cfgError(cfgError),
    .strobe(strobe)
  );

  sat_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .sdata(sdata), .underrun(underrun)
  );

  assign sampleReady = strobe.load;

endmodule

// File: rtl/sat_checker.sv
module sat_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [DIV_W-1:0] clkDiv,
  input logic             bclk,
  input logic             sampleReady,
  input logic             sampleValid,
  input logic             underrun,
  input logic             txEnd,
  input logic             sdata,
  input logic             cfgError
);
  assert_div_freeze_R1: assert property (@(posedge clk) disable iff (!rstN)
    (clkDiv == '0) |=> $stable(bclk));

  assert_ready_running_R8: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |-> !txEnd);

  assert_underrun_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> $past(sampleReady && !sampleValid));

  assert_reject_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgError && txEnd) |=> txEnd);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    txEnd |-> !sdata);

  assert_stop_on_edge_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnd) |-> (bclk != $past(bclk)));

endmodule

bind serial_audio_tx sat_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .bclk(bclk),
  .sampleReady(sampleReady), .sampleValid(sampleValid),
  .underrun(underrun), .txEnd(txEnd), .sdata(sdata), .cfgError(cfgError)
);

// File: tb/serial_audio_tx_tb.sv
`timescale 1ns/1ps
module serial_audio_tx_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enSet = 1'b0, enClr = 1'b0;
  logic        fmtDsp = 1'b0, stereo = 1'b0;
  logic [1:0]  widthSel = 2'd0;
  logic [7:0]  clkDiv = 8'd1, framePeriod = 8'd17;
  logic        sampleValid = 1'b1;
  logic [31:0] sampleData = 32'h0;
  logic        sampleReady, bclk, fsync, sdata, underrun, txEnd, cfgError;

  serial_audio_tx u_dut (
    .clk(clk), .rstN(rstN), .enSet(enSet), .enClr(enClr), .fmtDsp(fmtDsp),
    .widthSel(widthSel), .stereo(stereo), .clkDiv(clkDiv),
    .framePeriod(framePeriod), .sampleValid(sampleValid),
    .sampleData(sampleData), .sampleReady(sampleReady), .bclk(bclk),
    .fsync(fsync), .sdata(sdata), .underrun(underrun), .txEnd(txEnd),
    .cfgError(cfgError)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int framesSeen = 0;
  bit monOn = 0, undEn = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input int i);
    return (32'(i + 1) * 32'h9E37_79B1) ^ (32'(i) << 9) ^ 32'h0000_00FF;
  endfunction

  // monitor state
  logic [31:0] q[$];
  logic [31:0] cur = 0;
  int  idx = 0, readyCnt = 0, bpos = 0, halfCnt = 0;
  bit  advPending = 0, expUnder = 0, inFrame = 0, halfSeen = 0;
  logic prevBclk = 0, prevFs = 1, prevSd = 0, prevTxEnd = 1;

  always @(negedge clk) begin
    if (monOn) begin
      automatic int  w = 8 * (int'(widthSel) + 1);
      automatic int  dEnd = stereo ? 2 * w : w;
      automatic bit  edgeUpd = fmtDsp ? (bclk && !prevBclk) : (!bclk && prevBclk);
      automatic bit  startSeen;
      automatic bit  expFs, expSd;
      automatic int  k;
      if (advPending) begin
        idx++;
        sampleData = gen(idx);
        advPending = 0;
      end
      sampleValid = !(undEn && (readyCnt % 4 == 2));
      if (underrun || expUnder) check(underrun == expUnder, "R9 underrun pulse", underrun, expUnder);
      expUnder = sampleReady && !sampleValid;
      if (sampleReady) begin
        readyCnt++;
        q.push_back(sampleValid ? sampleData : 32'h0);
        if (sampleValid) advPending = 1;
      end
      // R1 half period
      halfCnt++;
      if (bclk != prevBclk) begin
        if (inFrame && halfSeen) check(halfCnt == int'(clkDiv), "R1 half period", halfCnt, clkDiv);
        halfSeen = inFrame;
        halfCnt = 0;
      end
      // R4/R5 update edge
      if (inFrame && (sdata != prevSd || fsync != prevFs))
        check(edgeUpd, fmtDsp ? "R5 update edge" : "R4 update edge", bclk, !prevBclk);
      if (txEnd && !prevTxEnd) begin
        check(edgeUpd && inFrame && bpos == int'(framePeriod) - 1, "R11 stop at boundary", bpos, framePeriod - 1);
        check(sdata == 1'b0 && fsync == !fmtDsp, "R11 idle lines", {sdata, fsync}, {1'b0, !fmtDsp});
        inFrame = 0;
        halfSeen = 0;
      end else if (edgeUpd && !txEnd) begin
        startSeen = fmtDsp ? fsync : (prevFs && !fsync);
        if (startSeen) begin
          if (inFrame) check(bpos == int'(framePeriod) - 1, "R7 frame length", bpos + 1, framePeriod);
          inFrame = 1;
          bpos = 0;
          framesSeen++;
        end else if (inFrame) begin
          bpos++;
        end
        if (inFrame) begin
          expFs = fmtDsp ? (bpos == 0) : (bpos >= w);
          check(fsync == expFs, fmtDsp ? "R5 sync shape" : "R3 sync shape", fsync, expFs);
          expSd = 1'b0;
          if (bpos >= 1 && bpos <= dEnd) begin
            k = (bpos - 1) % w;
            if (k == 0) begin
              if (q.size() == 0) begin
                check(0, "R8 word without sample", 0, 1);
                cur = 0;
              end else cur = q.pop_front();
            end
            expSd = cur[31 - k];
          end
          check(sdata == expSd, "R2 R6 data bit", sdata, expSd);
        end
      end
      prevBclk = bclk; prevFs = fsync; prevSd = sdata; prevTxEnd = txEnd;
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic runCombo(input bit dsp, input logic [1:0] ws, input bit st,
                          input logic [7:0] d, input logic [7:0] f, input bit und);
    int startF, guard;
    @(negedge clk);
    fmtDsp = dsp; widthSel = ws; stereo = st; clkDiv = d; framePeriod = f; undEn = und;
    repeat (3) @(negedge clk);
    check(cfgError == 1'b0, "R10 legal setting", cfgError, 0);
    startF = framesSeen;
    pulse(enSet);
    guard = 0;
    while (framesSeen < startF + 3 && guard < 20000) begin @(negedge clk); guard++; end
    check(framesSeen >= startF + 3, "R11 start", framesSeen - startF, 3);
    pulse(enClr);
    guard = 0;
    while (!txEnd && guard < 5000) begin @(negedge clk); guard++; end
    check(txEnd == 1'b1, "R11 stopped", txEnd, 1);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R8 one sample per word", q.size(), 0);
    q.delete();
    undEn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(txEnd == 1 && bclk == 0 && sdata == 0 && sampleReady == 0 && underrun == 0,
          "R12 reset state", {txEnd, bclk, sdata, sampleReady, underrun}, 5'b10000);
    rstN = 1'b1;
    @(negedge clk);
    check(txEnd == 1 && sdata == 0, "R12 after release", {txEnd, sdata}, 2'b10);
    sampleData = gen(0);
    monOn = 1;

    // sweep all legal width/channel/framing combos at the smallest frame plus some slack
    for (int dsp = 0; dsp < 2; dsp++)
      for (int ws = 0; ws < 4; ws++)
        for (int st = 0; st < 2; st++) begin
          if (dsp == 0 && ws >= 2) continue;
          runCombo(dsp[0], ws[1:0], st[0], 8'(1 + (ws + st) % 2),
                   8'(1 + 8 * (ws + 1) * (st + 1) + (dsp == 0 ? ws + 2 : 0)), ws == 1);
        end

    // R10 rejected settings
    @(negedge clk);
    fmtDsp = 0; widthSel = 2'd2; stereo = 1; clkDiv = 1; framePeriod = 8'd100;
    @(negedge clk);
    check(cfgError == 1, "R10 wide I2S flagged", cfgError, 1);
    widthSel = 2'd3;
    @(negedge clk);
    check(cfgError == 1, "R10 32-bit I2S flagged", cfgError, 1);
    pulse(enSet);
    repeat (400) @(negedge clk);
    check(txEnd == 1, "R10 no start", txEnd, 1);
    pulse(enClr);
    fmtDsp = 1; widthSel = 2'd0; stereo = 1; framePeriod = 8'd16;
    @(negedge clk);
    check(cfgError == 1, "R10 short frame flagged", cfgError, 1);
    framePeriod = 8'd17;
    @(negedge clk);
    check(cfgError == 0, "R10 minimum frame legal", cfgError, 0);

    // R1 zero divider freezes the clock
    clkDiv = 8'd0;
    repeat (4) @(negedge clk);
    begin
      logic b0;
      bit moved;
      b0 = bclk;
      moved = 0;
      pulse(enSet);
      repeat (60) begin @(negedge clk); if (bclk != b0) moved = 1; end
      check(!moved, "R1 frozen clock", moved, 0);
      check(txEnd == 1, "R1 no frame progress", txEnd, 1);
      pulse(enClr);
    end
    clkDiv = 8'd1;
    repeat (80) @(negedge clk);
    check(txEnd == 1, "R11 cleared request stays stopped", txEnd, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule